// File: doc/BRIEF.md
# Phase-Accumulator Sine Oscillator

This block is a numerically controlled oscillator. A 32-bit phase register, read as 8 integer bits over 24 fractional bits, advances by a frequency tuning word on every cycle where the sample enable is high. The upper 8 bits of the phase select one of 256 stored sine values. Each value is an unsigned byte centred on 128 with an amplitude of 127. The output frequency is tuning_word / 2^32 of the sample rate. The output byte is suited to a unipolar converter biased at half scale.

The tuning word can be replaced at any time through a load strobe. A load changes the frequency without touching the phase. When chirp mode is on, a signed 32-bit delta is added to the tuning word once per enabled sample, which gives a linear frequency sweep. A host computes the tuning word and the delta. This block only does fixed-point integer work.

Top module: `nco_sine_top`

## Requirements
- R1: Synchronous active-low reset clears the phase register and the tuning word to zero, sets `sample` to 128 and holds `sample_valid` low.
- R2: Stored entry i (0..255) equals round(127*sin(2*pi*i/256) + 128). Every output sample therefore lies in 1..255 and is never 0.
- R3: The table index is phase bits [31:24]. The 24 fractional bits are dropped by truncation, and carries out of the fraction advance the index.
- R4: On an enabled cycle the sample is read at the phase value held before that cycle's addition. The first enabled sample after reset is therefore entry 0 (128) for any tuning word.
- R5: The phase adds the tuning word in use modulo 2^32 and wraps through plain overflow.
- R6: While `sample_en` is low, the phase and `sample` keep their values.
- R7: `sample_valid` is high in exactly the cycle after each cycle with `sample_en` high, and low otherwise.
- R8: A load writes `tune_word` into the tuning register at the next edge, whether or not the sample enable is high. The phase is not disturbed. The step taken in the load cycle still uses the old word.
- R9: With `chirp_en` high, `tune_load` low and `sample_en` high, the tuning word becomes tuning word + `chirp_delta` (two's complement, modulo 2^32) at the edge. With `sample_en` low, no chirp update happens.
- R10: When `tune_load` and a chirp update fall in the same cycle, the loaded word is taken and the delta is ignored for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | Advance one sample this cycle |
| tune_load | input | 1 | Load strobe for the tuning word |
| tune_word | input | 32 | New tuning word (frequency * 2^32) |
| chirp_en | input | 1 | Add the chirp delta per enabled sample |
| chirp_delta | input | 32 | Signed per-sample tuning-word increment |
| sample | output | 8 | Offset-binary sine sample |
| sample_valid | output | 1 | New sample present this cycle |

## Verification
Three cases are the hardest to reach from the ports:
- A wrap of the tuning word itself under a negative chirp. A long positive sweep is followed by a negative delta large enough to carry the word below zero, so it wraps to a value near 2^32. The phase then steps backwards.
- A load and a chirp update in the same cycle. The stimulus pulses the load strobe while the chirp stays on, so the priority rule decides several consecutive samples.
- Truncation at the fractional boundary. A word of 0x00FFFFFF keeps the index on one entry until the fraction carries.

A behavioural reference using real-valued sine predicts every sample and valid flag, so each of these cases is checked on every cycle.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int PHASE_W  = 32;
    localparam int INDEX_W  = 8;
    localparam int SAMPLE_W = 8;
    localparam int FRAC_W   = PHASE_W - INDEX_W;
    localparam int DEPTH    = 1 << INDEX_W;

    typedef logic [PHASE_W-1:0]  phase_t;
    typedef logic [INDEX_W-1:0]  index_t;
    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        phase_t word;
    } tune_state_t;

    typedef struct packed {
        phase_t phase;
    } accum_state_t;

    typedef struct packed {
        sample_t value;
        logic    valid;
    } out_state_t;
endpackage

// File: rtl/nco_sine_rom.sv
module nco_sine_rom
    import nco_pkg::*;
(
    input  index_t  idx_i,
    output sample_t value_o
);
    localparam int HALF    = DEPTH / 2;
    localparam int QUARTER = DEPTH / 4;
    localparam int MID     = 1 << (SAMPLE_W - 1);
    localparam int AMP     = MID - 1;

    // Sine of a first-quadrant angle by series expansion.
    function automatic real quad_sin(input real x);
        real term;
        real sum;
        term = x;
        sum  = x;
        for (int k = 1; k < 14; k++) begin
            term = -term * x * x / ((2.0 * k) * (2.0 * k + 1.0));
            sum  = sum + term;
        end
        return sum;
    endfunction

    function automatic sample_t entry_value(input int i);
        int  pos;
        int  r;
        real s;
        real pi_v;
        int  v;
        pi_v = 3.14159265358979323846;
        pos  = i % DEPTH;
        r    = (pos >= HALF) ? pos - HALF : pos;
        if (r > QUARTER) r = HALF - r;
        s = quad_sin(2.0 * pi_v * r / DEPTH);
        if (pos >= HALF) s = -s;
        v = $rtoi(AMP * s + MID + 0.5);
        return sample_t'(v);
    endfunction

    sample_t table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam sample_t ENTRY = entry_value(g);
        assign table_w[g] = ENTRY;
    end

    assign value_o = table_w[idx_i];
endmodule

// File: rtl/nco_tuning.sv
module nco_tuning
    import nco_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    input  logic   load_i,
    input  phase_t load_word_i,
    input  logic   chirp_en_i,
    input  phase_t chirp_delta_i,
    output phase_t word_o
);
    tune_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.word = load_word_i;
        end else if (step_en && chirp_en_i) begin
            st_d.word = st_q.word + chirp_delta_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (word_o == $past(load_word_i)));  // R10
    AST_CHIRP_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && chirp_en_i && !load_i) |=> (word_o == $past(word_o) + $past(chirp_delta_i)));  // R9
    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(step_en && chirp_en_i)) |=> $stable(word_o));  // R8
endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum
    import nco_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    input  phase_t word_i,
    output index_t index_o
);
    accum_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            st_d.phase = st_q.phase + word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Integer part only: fractional bits are discarded.
    assign index_o = st_q.phase[PHASE_W-1 -: INDEX_W];

    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(st_q.phase));  // R6
    AST_PHASE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ($past(1'b1) == 1'b1)) |=> (st_q.phase - $past(st_q.phase) == $past(word_i)));  // R5
endmodule

// File: rtl/nco_sine_top.sv
module nco_sine_top
    import nco_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sample_en,
    input  logic        tune_load,
    input  logic [31:0] tune_word,
    input  logic        chirp_en,
    input  logic [31:0] chirp_delta,
    output logic [7:0]  sample,
    output logic        sample_valid
);
    localparam sample_t RESET_SAMPLE = sample_t'(1 << (SAMPLE_W - 1));

    phase_t     word_w;
    index_t     index_w;
    sample_t    rom_w;
    out_state_t st_d, st_q;

    nco_tuning u_tuning (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_en       (sample_en),
        .load_i        (tune_load),
        .load_word_i   (tune_word),
        .chirp_en_i    (chirp_en),
        .chirp_delta_i (chirp_delta),
        .word_o        (word_w)
    );

    nco_phase_accum u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (sample_en),
        .word_i  (word_w),
        .index_o (index_w)
    );

    nco_sine_rom u_rom (
        .idx_i   (index_w),
        .value_o (rom_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = sample_en;
        if (sample_en) begin
            st_d.value = rom_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.value <= RESET_SAMPLE;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample       = st_q.value;
    assign sample_valid = st_q.valid;

    AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> sample_valid);  // R7
    AST_VALID_ONLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> !sample_valid);  // R7
    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(sample));  // R6
    AST_SAMPLE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sample != '0);  // R2
endmodule

// File: tb/test_nco_sine_top.sv
`timescale 1ns/1ps
module test_nco_sine_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_en;
    logic        tune_load;
    logic [31:0] tune_word;
    logic        chirp_en;
    logic [31:0] chirp_delta;
    logic [7:0]  sample;
    logic        sample_valid;

    always #2 clk = ~clk;  // 250 MHz

    nco_sine_top i_nco_sine_top (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tune_load(tune_load),
        .tune_word(tune_word), .chirp_en(chirp_en), .chirp_delta(chirp_delta),
        .sample(sample), .sample_valid(sample_valid)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string tag    = "R1";
    int    ref_tbl [256];

    // Reference model state
    logic [31:0] m_phase, m_word;
    logic [7:0]  m_sample;
    logic        m_valid;
    bit          live = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            ref_tbl[i] = $rtoi(127.0 * $sin(2.0 * 3.14159265358979323846 * i / 256.0) + 128.5);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_word = 0; m_sample = 8'd128; m_valid = 0;
        end else begin
            logic [31:0] nw;
            nw = m_word;
            if (tune_load) nw = tune_word;
            else if (sample_en && chirp_en) nw = m_word + chirp_delta;
            if (sample_en) begin
                m_sample = 8'(ref_tbl[m_phase >> 24]);
                m_phase  = m_phase + m_word;
            end
            m_valid = sample_en;
            m_word  = nw;
        end
        live = 1;
    end

    always @(negedge clk) begin
        if (live) begin
            chk(tag, "sample", sample, m_sample);
            chk(tag, "valid", sample_valid, m_valid);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(logic [31:0] w);
        tune_load = 1; tune_word = w;
        cyc(1);
        tune_load = 0;
    endtask

    initial begin
        rst_n = 0; sample_en = 0; tune_load = 0; tune_word = 0;
        chirp_en = 0; chirp_delta = 0;
        cyc(4);
        tag = "R1";
        chk("R1", "reset sample", sample, 128);
        chk("R1", "reset valid", sample_valid, 0);
        rst_n = 1;

        // R4: first sample after reset is entry 0 whatever the word
        tag = "R4";
        load(32'h4000_0000);
        sample_en = 1;
        cyc(1);
        chk("R4", "first sample", sample, 128);
        cyc(1);
        chk("R4", "quarter step", sample, 255);
        cyc(1);
        chk("R4", "half step", sample, 128);
        cyc(1);
        chk("R4", "three quarter", sample, 1);
        sample_en = 0;

        // R2: one entry per sample sweeps the whole table
        tag = "R2";
        load(32'h0100_0000);
        sample_en = 1;
        cyc(520);

        // R3: fraction just below one index step
        tag = "R3";
        load(32'h00FF_FFFF);
        cyc(300);

        // R6 / R7: sparse enable pattern
        tag = "R6";
        load(32'h0A3D_70A4);
        for (int k = 0; k < 90; k++) begin
            sample_en = (k % 3 == 0);
            cyc(1);
        end
        tag = "R7";
        for (int k = 0; k < 40; k++) begin
            sample_en = (k % 2 == 1);
            cyc(1);
        end

        // R8: loads in the middle of a run, with and without enable
        tag = "R8";
        sample_en = 1;
        for (int k = 0; k < 6; k++) begin
            sample_en = (k % 2 == 0);
            load(32'h0123_4567 * (k + 1));
            sample_en = 1;
            cyc(15);
        end

        // R5: phase overflow every step
        tag = "R5";
        load(32'hF000_0001);
        cyc(60);

        // R9: rising chirp then a falling chirp that wraps the word
        tag = "R9";
        load(32'h0010_0000);
        chirp_delta = 32'h0000_8000; chirp_en = 1;
        cyc(600);
        chirp_delta = -32'sd2097152;
        cyc(300);
        sample_en = 0;
        cyc(5);
        sample_en = 1;
        cyc(20);

        // R10: load and chirp together
        tag = "R10";
        chirp_delta = 32'h0100_0000;
        for (int k = 0; k < 30; k++) begin
            tune_load = (k % 3 != 2);
            tune_word = 32'h0200_0000 + k;
            cyc(1);
        end
        tune_load = 0; chirp_en = 0;
        cyc(20);

        report();
        $finish;
    end
endmodule